// File: doc/BRIEF.md
# Multi-PHY Transmit Cell Scheduler with Head-of-Line Flush

This block sits between a shared transmit cell FIFO and a cell-level master bus that serves up to eight PHY ports. It takes the cell at the head of the FIFO and drives that cell's port address towards the PHYs. When the addressed PHY reports cell-available, it streams all 53 octets of the cell, one per clock, and marks the first octet with a start-of-cell pulse. While the FIFO is empty and no cell is in progress, it raises an idle flag.

A PHY that never reports cell-available would otherwise stall every port queued behind it. A wait counter therefore restarts each time a port address is driven. When a flush-enable bit is set and the counter reaches a host-programmed 16-bit limit, the head cell is dropped from the FIFO in a single operation and a sticky status bit is set for that port. The port stays in service, so later cells for it are tried normally. The status bits drive an interrupt through a per-port enable mask and clear when the host reads them.

The host can also take a port out of service. Cells for a disabled port are dropped without polling. Such drops set no status bit and raise no interrupt. The host reaches the configuration through a small register bus with single-cycle writes and registered reads.

Top module: `txcell_hol_flusher`

## Requirements
- R1: A sent cell is exactly 53 consecutive cycles with `tx_enb_o`=1. `tx_soc_o` is 1 on the first of these cycles only. `tx_data_o` carries the FIFO octets in order, and `fifo_rd_o` pops one octet in each of these cycles.
- R2: `tx_idle_o` is 1 exactly when the FIFO is empty and no cell is being polled or sent. While it is 1, `tx_enb_o` is 0.
- R3: With the flush-enable bit at 0, the head cell for an enabled port is polled indefinitely and is never dropped.
- R4: A cell for an enabled port is taken in an idle cycle, and `phy_addr_vld_o` is 1 from the next cycle on. The wait count is 0 in the first poll cycle and rises by 1 in each further poll cycle. When `phy_clav_i` is 1 in a poll cycle, sending starts in the next cycle and no status is recorded.
- R5: With flush enabled and `phy_clav_i` at 0, the block drops the cell in the poll cycle whose wait count equals the limit, so a limit of 0 drops in the first poll cycle. It pulses `fifo_drop_o` for that one cycle, sets the status bit of the addressed port, and returns to idle. The next cell polled starts again from a count of 0.
- R6: A drop emits no octet and pops no octet through `fifo_rd_o`. The port stays enabled, and a later cell for it is sent when its PHY answers.
- R7: `irq_o` is 1 exactly when some status bit and the matching interrupt-enable bit are both 1.
- R8: A read of the status register returns the status bits and clears them. A timeout drop in the same cycle as the read leaves its bit set.
- R9: When the port-disable bit of the head cell's port is 1, the cell is dropped from the idle state without polling (`fifo_drop_o`=1 while `phy_addr_vld_o`=0). No status bit is set and no interrupt is raised.
- R10: The registers are selected by `reg_addr_i`:
  - 0: flush enable, bit 0; reset value 0.
  - 1: wait limit, bits 15:0; reset value 0xFFFF.
  - 2: port disable, one bit per port, bit n for port n; reset value 0.
  - 3: interrupt enable, one bit per port, bit n for port n; reset value 0.
  - 4: status, one bit per port, bit n for port n; read only.

  Read data appears on `reg_rdata_o` in the cycle after `reg_re_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_empty_i | input | 1 | Cell FIFO holds no cell |
| fifo_port_i | input | 3 | Destination port of the head cell |
| fifo_data_i | input | 8 | Octet at the FIFO read position |
| fifo_rd_o | output | 1 | Pop one octet |
| fifo_drop_o | output | 1 | Pop the whole head cell |
| phy_addr_o | output | 3 | Port address being polled |
| phy_addr_vld_o | output | 1 | Port address is driven (poll cycle) |
| phy_clav_i | input | 1 | Addressed PHY can take a cell |
| tx_data_o | output | 8 | Transmit octet |
| tx_soc_o | output | 1 | First octet of a cell |
| tx_enb_o | output | 1 | Transmit octet valid |
| tx_idle_o | output | 1 | No data to transfer |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| irq_o | output | 1 | Masked discard interrupt |

## Verification
The following are checked on every cycle:
- every cell is 53 octets long and starts with the start-of-cell mark;
- the block never sends while idle;
- no drop occurs during polling while flush is disabled;
- a drop never overlaps an octet pop;
- a timeout drop sets its port's status bit;
- a status read clears the bits;
- a disabled-port drop leaves the status unchanged.

Some behaviour can only be shown by the bench scenarios:
- a timeout falls exactly in the poll cycle that matches the limit;
- the octet data and its order are correct;
- a port keeps working after its cell was flushed;
- the masked interrupt follows the status bits;
- a drop in the same cycle as a status read keeps its bit.

// File: rtl/hof_pkg.sv
package hof_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_POLL, ST_SEND} seq_state_e;

  localparam int unsigned REG_AW = 3;
  localparam logic [REG_AW-1:0] RA_CFG   = 3'd0;
  localparam logic [REG_AW-1:0] RA_LIMIT = 3'd1;
  localparam logic [REG_AW-1:0] RA_PDIS  = 3'd2;
  localparam logic [REG_AW-1:0] RA_IEN   = 3'd3;
  localparam logic [REG_AW-1:0] RA_STAT  = 3'd4;
endpackage

// File: rtl/hof_regs.sv
module hof_regs import hof_pkg::*; #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned REG_W     = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic                 re_i,
  input  logic [REG_AW-1:0]    addr_i,
  input  logic [REG_W-1:0]     wdata_i,
  input  logic [NUM_PORTS-1:0] stat_set_i,
  output logic                 flush_en_o,
  output logic [CNT_W-1:0]     limit_o,
  output logic [NUM_PORTS-1:0] port_dis_o,
  output logic [NUM_PORTS-1:0] irq_en_o,
  output logic [NUM_PORTS-1:0] stat_o,
  output logic [REG_W-1:0]     rdata_o,
  output logic                 irq_o
);
  logic                 flush_q;
  logic [CNT_W-1:0]     limit_q;
  logic [NUM_PORTS-1:0] dis_q, ien_q, stat_q, stat_d;
  logic [REG_W-1:0]     rdata_q, rd_mux;
  logic                 stat_clr;

  assign stat_clr = re_i && (addr_i == RA_STAT);
  // a discard landing on the read cycle survives the clear
  assign stat_d   = (stat_clr ? '0 : stat_q) | stat_set_i;

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      RA_CFG:   rd_mux[0]             = flush_q;
      RA_LIMIT: rd_mux[CNT_W-1:0]     = limit_q;
      RA_PDIS:  rd_mux[NUM_PORTS-1:0] = dis_q;
      RA_IEN:   rd_mux[NUM_PORTS-1:0] = ien_q;
      RA_STAT:  rd_mux[NUM_PORTS-1:0] = stat_q;
      default:  rd_mux                = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_q <= 1'b0;
      limit_q <= '1;
      dis_q   <= '0;
      ien_q   <= '0;
      stat_q  <= '0;
      rdata_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (re_i) rdata_q <= rd_mux;
      if (we_i) begin
        case (addr_i)
          RA_CFG:   flush_q <= wdata_i[0];
          RA_LIMIT: limit_q <= wdata_i[CNT_W-1:0];
          RA_PDIS:  dis_q   <= wdata_i[NUM_PORTS-1:0];
          RA_IEN:   ien_q   <= wdata_i[NUM_PORTS-1:0];
          default:  ;
        endcase
      end
    end
  end

  assign flush_en_o = flush_q;
  assign limit_o    = limit_q;
  assign port_dis_o = dis_q;
  assign irq_en_o   = ien_q;
  assign stat_o     = stat_q;
  assign rdata_o    = rdata_q;
  assign irq_o      = |(stat_q & ien_q);
endmodule

// File: rtl/hof_wait_ctr.sv
module hof_wait_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (inc_i && ~&cnt_q)  cnt_q <= cnt_q + 1'b1;  // saturate while flush is off
  end

  assign hit_o = (cnt_q == limit_i);
endmodule

// File: rtl/hof_cell_seq.sv
module hof_cell_seq import hof_pkg::*; #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned CELL_LEN  = 53,
  localparam int unsigned PORT_W   = $clog2(NUM_PORTS),
  localparam int unsigned OCT_W    = $clog2(CELL_LEN)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fifo_empty_i,
  input  logic [PORT_W-1:0]    fifo_port_i,
  input  logic [NUM_PORTS-1:0] port_dis_i,
  input  logic                 flush_en_i,
  input  logic                 wait_hit_i,
  input  logic                 clav_i,
  output logic                 fifo_rd_o,
  output logic                 fifo_drop_o,
  output logic                 tx_enb_o,
  output logic                 tx_soc_o,
  output logic                 tx_idle_o,
  output logic [PORT_W-1:0]    phy_addr_o,
  output logic                 phy_addr_vld_o,
  output logic                 wait_clr_o,
  output logic                 wait_inc_o,
  output logic [NUM_PORTS-1:0] stat_set_o
);
  seq_state_e        state_q, state_d;
  logic [PORT_W-1:0] port_q, port_d;
  logic [OCT_W-1:0]  oct_q, oct_d;
  logic              timeout;

  assign timeout = (state_q == ST_POLL) && !clav_i && flush_en_i && wait_hit_i;

  always_comb begin
    state_d     = state_q;
    port_d      = port_q;
    oct_d       = oct_q;
    fifo_drop_o = 1'b0;
    case (state_q)
      ST_IDLE: if (!fifo_empty_i) begin
        if (port_dis_i[fifo_port_i]) begin
          fifo_drop_o = 1'b1;
        end else begin
          port_d  = fifo_port_i;
          state_d = ST_POLL;
        end
      end
      ST_POLL: begin
        if (clav_i) begin
          oct_d   = '0;
          state_d = ST_SEND;
        end else if (timeout) begin
          fifo_drop_o = 1'b1;
          state_d     = ST_IDLE;
        end
      end
      ST_SEND: begin
        oct_d = oct_q + 1'b1;
        if (oct_q == OCT_W'(CELL_LEN - 1)) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      port_q  <= '0;
      oct_q   <= '0;
    end else begin
      state_q <= state_d;
      port_q  <= port_d;
      oct_q   <= oct_d;
    end
  end

  always_comb begin
    stat_set_o = '0;
    if (timeout && !port_dis_i[port_q]) stat_set_o[port_q] = 1'b1;
  end

  assign fifo_rd_o      = (state_q == ST_SEND);
  assign tx_enb_o       = (state_q == ST_SEND);
  assign tx_soc_o       = (state_q == ST_SEND) && (oct_q == '0);
  assign tx_idle_o      = (state_q == ST_IDLE) && fifo_empty_i;
  assign phy_addr_o     = port_q;
  assign phy_addr_vld_o = (state_q == ST_POLL);
  assign wait_clr_o     = (state_q != ST_POLL);
  assign wait_inc_o     = (state_q == ST_POLL) && !clav_i;
endmodule

// File: rtl/txcell_hol_flusher.sv
module txcell_hol_flusher import hof_pkg::*; #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned REG_W     = 16,
  parameter int unsigned CELL_LEN  = 53,
  localparam int unsigned PORT_W   = $clog2(NUM_PORTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fifo_empty_i,
  input  logic [PORT_W-1:0] fifo_port_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic              fifo_rd_o,
  output logic              fifo_drop_o,
  output logic [PORT_W-1:0] phy_addr_o,
  output logic              phy_addr_vld_o,
  input  logic              phy_clav_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_soc_o,
  output logic              tx_enb_o,
  output logic              tx_idle_o,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  logic                 flush_en, wait_hit, wait_clr, wait_inc;
  logic [CNT_W-1:0]     wait_limit;
  logic [NUM_PORTS-1:0] port_dis, irq_en, stat, stat_set;

  hof_regs #(.NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .re_i(reg_re_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .stat_set_i(stat_set),
    .flush_en_o(flush_en), .limit_o(wait_limit), .port_dis_o(port_dis),
    .irq_en_o(irq_en), .stat_o(stat), .rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  hof_wait_ctr #(.CNT_W(CNT_W)) u_wait (
    .clk_i, .rst_ni,
    .clr_i(wait_clr), .inc_i(wait_inc), .limit_i(wait_limit), .hit_o(wait_hit)
  );

  hof_cell_seq #(.NUM_PORTS(NUM_PORTS), .CELL_LEN(CELL_LEN)) u_seq (
    .clk_i, .rst_ni,
    .fifo_empty_i, .fifo_port_i, .port_dis_i(port_dis), .flush_en_i(flush_en),
    .wait_hit_i(wait_hit), .clav_i(phy_clav_i),
    .fifo_rd_o, .fifo_drop_o, .tx_enb_o, .tx_soc_o, .tx_idle_o,
    .phy_addr_o, .phy_addr_vld_o,
    .wait_clr_o(wait_clr), .wait_inc_o(wait_inc), .stat_set_o(stat_set)
  );

  assign tx_data_o = fifo_data_i;

  // irq enable mirror kept for the checker's view
  logic [NUM_PORTS-1:0] irq_en_seen;
  assign irq_en_seen = irq_en;
endmodule

// File: rtl/hof_checker.sv
module hof_checker import hof_pkg::*; #(
  parameter int unsigned NUM_PORTS = 8,
  parameter int unsigned CELL_LEN  = 53,
  localparam int unsigned PORT_W   = $clog2(NUM_PORTS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 tx_enb_o,
  input logic                 tx_soc_o,
  input logic                 tx_idle_o,
  input logic                 fifo_drop_o,
  input logic                 fifo_rd_o,
  input logic                 phy_addr_vld_o,
  input logic [PORT_W-1:0]    phy_addr_o,
  input logic                 flush_en,
  input logic [NUM_PORTS-1:0] port_dis,
  input logic [NUM_PORTS-1:0] stat,
  input logic                 reg_re_i,
  input logic [REG_AW-1:0]    reg_addr_i
);
  int unsigned run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       run_q <= 0;
    else if (tx_enb_o) run_q <= tx_soc_o ? 1 : run_q + 1;
  end

  p_cell_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_enb_o) |-> run_q == CELL_LEN);
  p_soc_enb_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_soc_o |-> tx_enb_o && fifo_rd_o);
  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_idle_o |-> !tx_enb_o && !phy_addr_vld_o);
  p_no_flush_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phy_addr_vld_o && !flush_en) |-> !fifo_drop_o);
  p_stat_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_drop_o && phy_addr_vld_o && !port_dis[phy_addr_o]) |=> stat[$past(phy_addr_o)]);
  p_drop_clean_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_drop_o |-> !fifo_rd_o && !tx_enb_o);
  p_clear_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_re_i && reg_addr_i == RA_STAT && !fifo_drop_o) |=> stat == '0);
  p_dis_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_drop_o && !phy_addr_vld_o && !(reg_re_i && reg_addr_i == RA_STAT)) |=> $stable(stat));
endmodule

bind txcell_hol_flusher hof_checker #(.NUM_PORTS(NUM_PORTS), .CELL_LEN(CELL_LEN)) u_hof_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_enb_o(tx_enb_o), .tx_soc_o(tx_soc_o),
  .tx_idle_o(tx_idle_o), .fifo_drop_o(fifo_drop_o), .fifo_rd_o(fifo_rd_o),
  .phy_addr_vld_o(phy_addr_vld_o), .phy_addr_o(phy_addr_o), .flush_en(flush_en),
  .port_dis(port_dis), .stat(stat), .reg_re_i(reg_re_i), .reg_addr_i(reg_addr_i)
);

// File: tb/txcell_hol_flusher_bench.sv
`timescale 1ns/100ps
module txcell_hol_flusher_bench;
  localparam int CL = 53;
  localparam int QD = 1024;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic        fifo_empty_i, fifo_rd_o, fifo_drop_o, phy_addr_vld_o, phy_clav_i;
  logic [2:0]  fifo_port_i, phy_addr_o, reg_addr_i;
  logic [7:0]  fifo_data_i, tx_data_o;
  logic        tx_soc_o, tx_enb_o, tx_idle_o, reg_we_i, reg_re_i, irq_o;
  logic [15:0] reg_wdata_i, reg_rdata_o;

  txcell_hol_flusher u_txcell_hol_flusher (.*);

  int total = 0, bad = 0;
  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // FIFO model
  int q_port[QD];
  int q_tag[QD];
  int qh = 0, qt = 0, oct = 0, tag_n = 1;
  function automatic logic [7:0] oct_val(int tg, int i);
    return 8'((tg * 37 + i * 11 + 5) ^ (i << 3));
  endfunction
  assign fifo_empty_i = (qh == qt);
  assign fifo_port_i  = 3'(q_port[qh]);
  assign fifo_data_i  = oct_val(q_tag[qh], oct);
  always @(posedge clk_i) begin
    if (fifo_drop_o) begin
      qh <= qh + 1; oct <= 0;
    end else if (fifo_rd_o) begin
      if (oct == CL - 1) begin qh <= qh + 1; oct <= 0; end
      else oct <= oct + 1;
    end
  end
  task automatic push(int p);
    q_port[qt] = p; q_tag[qt] = tag_n; tag_n++; qt++;
  endtask

  // PHY model
  int pc = 0;
  int dly[8];
  bit alive[8];
  always @(posedge clk_i) pc <= phy_addr_vld_o ? pc + 1 : 0;
  assign phy_clav_i = phy_addr_vld_o && alive[phy_addr_o] && (pc >= dly[phy_addr_o]);

  // configuration mirror
  bit         m_flush = 0;
  int         m_limit = 65535;
  logic [7:0] m_dis = '0, m_ien = '0, m_stat = '0;

  // 0 send, 1 disabled drop, 2 timeout drop
  function automatic int predict(int p);
    if (m_dis[p]) return 1;
    if (alive[p] && (!m_flush || dly[p] <= m_limit)) return 0;
    return 2;
  endfunction

  int  rx = 0, n_sent = 0, n_to = 0, n_dis = 0, got = 0, ex = 0;
  bit  rx_err = 0;
  always @(negedge clk_i) if (rst_ni) begin
    if (tx_enb_o) begin
      if ((tx_soc_o != (rx == 0)) || (tx_data_o != oct_val(q_tag[qh], rx)) || !fifo_rd_o) rx_err = 1;
      if (rx == CL - 1) begin
        check(!rx_err && predict(q_port[qh]) == 0, "R1 cell octets/outcome", int'(rx_err), 0);
        rx = 0; rx_err = 0; n_sent++;
      end else rx++;
    end
    if (fifo_drop_o) begin
      got = phy_addr_vld_o ? 2 : 1;
      ex  = predict(q_port[qh]);
      check(got == ex && rx == 0, ex == 1 ? "R9 drop kind" : "R5 drop kind", got, ex);
      if (got == 2) begin
        check(pc == m_limit, "R5 timeout cycle", pc, m_limit);
        n_to++;
        if (!m_dis[q_port[qh]]) m_stat[q_port[qh]] = 1'b1;
      end else n_dis++;
    end
  end

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk_i); reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 0;
  endtask
  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk_i); reg_re_i = 1; reg_addr_i = a;
    @(negedge clk_i); reg_re_i = 0; d = reg_rdata_o;
  endtask
  task automatic cfg(bit fl, int lim, logic [7:0] dis, logic [7:0] ien);
    wr(3'd0, {15'd0, fl}); m_flush = fl;
    wr(3'd1, 16'(lim));    m_limit = lim;
    wr(3'd2, {8'd0, dis}); m_dis = dis;
    wr(3'd3, {8'd0, ien}); m_ien = ien;
  endtask
  task automatic drain();
    repeat (2) @(negedge clk_i);
    while (!tx_idle_o) @(negedge clk_i);
  endtask
  task automatic chk_stat(string tag);
    logic [15:0] d;
    rd(3'd4, d);
    check(d == {8'd0, m_stat}, tag, int'(d), int'(m_stat));
    m_stat = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    check(0, "WATCHDOG", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int s0;
    void'($urandom(32'd20240611));
    reg_we_i = 0; reg_re_i = 0; reg_addr_i = '0; reg_wdata_i = '0;
    for (int i = 0; i < 8; i++) begin alive[i] = 1; dly[i] = 2; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // reset state
    check(tx_idle_o == 1, "R2 idle at reset", int'(tx_idle_o), 1);
    check(tx_enb_o == 0 && irq_o == 0, "R7 quiet at reset", int'(irq_o), 0);
    rd(3'd1, d); check(d == 16'hFFFF, "R10 limit reset", int'(d), 65535);
    rd(3'd0, d); check(d == 0, "R10 cfg reset", int'(d), 0);

    // R4: clav in the first poll cycle, limit 0
    cfg(1, 0, 8'h00, 8'h00);
    dly[1] = 0; s0 = n_sent; push(1); drain();
    check(n_sent == s0 + 1, "R4 immediate clav sends", n_sent - s0, 1);
    chk_stat("R4 no status on send");

    // R3: flush off, PHY answers after 30 polls, limit 2
    cfg(0, 2, 8'h00, 8'h00);
    dly[5] = 30; s0 = n_to; push(5); push(2); drain();
    check(n_to == s0, "R3 no drop with flush off", n_to - s0, 0);
    check(rx == 0, "R3 whole cells only", rx, 0);

    // R5: timeout at limit 6 and limit 0
    cfg(1, 6, 8'h00, 8'h00);
    alive[3] = 0; s0 = n_to; push(3); drain();
    check(n_to == s0 + 1, "R5 timeout drop", n_to - s0, 1);
    wr(3'd1, 16'd0); m_limit = 0;
    alive[4] = 0; push(4); drain();
    check(n_to == s0 + 2, "R5 limit zero drop", n_to - s0, 2);

    // R6: port still served after its flush
    alive[3] = 1; dly[3] = 0; s0 = n_sent; push(3); drain();
    check(n_sent == s0 + 1, "R6 port kept after flush", n_sent - s0, 1);

    // R7: masked interrupt
    @(negedge clk_i);
    check(irq_o == 0, "R7 masked off", int'(irq_o), 0);
    wr(3'd3, 16'h0008); m_ien = 8'h08; @(negedge clk_i);
    check(irq_o == 1, "R7 port3 enabled", int'(irq_o), 1);
    wr(3'd3, 16'h0010); m_ien = 8'h10; @(negedge clk_i);
    check(irq_o == 1, "R7 port4 enabled", int'(irq_o), 1);
    wr(3'd3, 16'h00E7); m_ien = 8'hE7; @(negedge clk_i);
    check(irq_o == 0, "R7 other bits masked", int'(irq_o), 0);

    // R8: read returns and clears
    chk_stat("R8 status read");
    rd(3'd4, d); check(d == 0, "R8 cleared after read", int'(d), 0);

    // R9: disabled port dropped quietly
    cfg(1, 5, 8'h40, 8'hFF);
    alive[6] = 0; s0 = n_dis; push(6); drain();
    check(n_dis == s0 + 1, "R9 disabled drop", n_dis - s0, 1);
    @(negedge clk_i);
    check(irq_o == 0, "R9 no irq", int'(irq_o), 0);
    chk_stat("R9 no status");

    // R8: discard in the read cycle wins
    cfg(1, 4, 8'h00, 8'h00);
    alive[3] = 0; push(3); drain();
    alive[4] = 0; push(4);
    do @(negedge clk_i); while (!fifo_drop_o);
    reg_re_i = 1; reg_addr_i = 3'd4;
    @(negedge clk_i); reg_re_i = 0; d = reg_rdata_o;
    check(d == 16'h0008, "R8 read before same-cycle set", int'(d), 8);
    m_stat = 8'h10;
    drain();
    chk_stat("R8 same-cycle set survives");

    // constrained random rounds
    for (int r = 0; r < 24; r++) begin
      bit fl;
      logic [7:0] dis;
      fl  = (r % 5) != 4;
      dis = 8'($urandom) & 8'($urandom);
      for (int i = 0; i < 8; i++) begin
        alive[i] = fl ? (($urandom % 4) != 0) : 1'b1;
        dly[i]   = $urandom % 12;
      end
      cfg(fl, $urandom % 10, dis, 8'($urandom));
      for (int c = 0; c < 6; c++) push($urandom % 8);
      drain();
      @(negedge clk_i);
      check(irq_o == |(m_stat & m_ien), "R7 random irq", int'(irq_o), int'(|(m_stat & m_ien)));
      chk_stat("R8 random status");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule